// File: doc/BRIEF.md
# Shared-Index XY Block Decoder

This block turns one compressed 64-bit tile of a two-channel normal map into the
8-bit x and 8-bit y values of a single texel. A tile covers a 4x4 group of
texels. It carries two 16-bit endpoints, each an (x, y) pair, and sixteen 2-bit
codes, one per texel. A texel's code selects one of four points on the segment
between the endpoints. The same code drives both channels, so each tile can hold
at most four distinct (x, y) values, at a cost of 4 bits per texel.

A request carries the whole tile and a 4-bit texel number, with a valid/ready
handshake. The tile is decoded combinationally, and the result lands in a single
output register that also has a valid/ready handshake. That register is run by a
two-state controller. In `ST_EMPTY` the register holds nothing. In `ST_FULL` it
holds a result that the consumer has not yet taken. The transitions are:
- `EMPTY->FULL` when a request is accepted.
- `FULL->FULL` when the held result is stalled, or is taken while a new request is accepted in the same cycle.
- `FULL->EMPTY` when the result is taken and no new request arrives.

Z reconstruction, filtering and address generation belong to other blocks.

Top module: `xyb_decode`

## Requirements
- R1: Code 0 returns endpoint 0 unchanged: x = tile[15:8], y = tile[7:0].
- R2: Code 1 returns endpoint 1 unchanged: x = tile[31:24], y = tile[23:16].
- R3: Code 2 returns, per channel, (2*e0 + e1)/3 rounded to the nearest integer.
- R4: Code 3 returns, per channel, (e0 + 2*e1)/3 rounded to the nearest integer.
- R5: Texel n (row-major, 0..15) takes its code from tile bits [33+2n:32+2n].
- R6: One code drives both channels of a texel. The x and y results always come from the same code.
- R7: A request accepted at a clock edge appears at the output with out_valid high right after that edge, which is a latency of one cycle.
- R8: After reset, out_valid is low and in_ready is high.
- R9: While out_valid is high and out_ready is low, out_x, out_y and out_valid hold. Every accepted request yields exactly one output, in order, with none lost and none repeated.
- R10: in_ready is high exactly when the output register is empty or is being drained in the same cycle. This gives one result per cycle with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_block | input | 64 | Compressed tile |
| in_texel | input | 4 | Texel number, row-major |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_x | output | 8 | Decoded x channel |
| out_y | output | 8 | Decoded y channel |

## Verification
A controller stuck in the wrong state shows up in one of three ways. The next
result is lost, it is presented twice, or in_ready is held low for no reason. The
scoreboard sees each of these as a missing, extra or out-of-order item on the
next transfer. A wrong code slice or a wrong blend weight corrupts the value of
the very next result that uses that code. The tiles are chosen so that every code
value appears in every texel position, which makes such a fault visible within a
few transfers.

// File: rtl/xyb_pkg.sv
package xyb_pkg;

    // Per-texel interpolation code
    typedef enum logic [1:0] {
        SEL_END0  = 2'd0,
        SEL_END1  = 2'd1,
        SEL_NEAR0 = 2'd2,
        SEL_NEAR1 = 2'd3
    } sel_e;

    // Output register occupancy
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_e;

endpackage

// File: rtl/xyb_fields.sv
module xyb_fields
    import xyb_pkg::*;
#(
    parameter int CH_W   = 8,
    parameter int TEXELS = 16,
    parameter int NCH    = 2,
    parameter int IDX_W  = $clog2(TEXELS),
    parameter int END_W  = NCH * CH_W,
    parameter int ANCH_W = 2 * END_W,
    parameter int BLK_W  = ANCH_W + 2 * TEXELS
) (
    input  logic [BLK_W-1:0]          blk,
    input  logic [IDX_W-1:0]          idx,
    output logic [NCH-1:0][CH_W-1:0]  end0,
    output logic [NCH-1:0][CH_W-1:0]  end1,
    output sel_e                      sel
);

    // Channel c of endpoint k sits at k*END_W + c*CH_W (channel 0 = y, 1 = x)
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign end0[c] = blk[c*CH_W +: CH_W];
        assign end1[c] = blk[END_W + c*CH_W +: CH_W];
    end

    // Code pick: texel t owns bits ANCH_W + 2t +: 2
    always_comb begin
        sel = SEL_END0;
        for (int t = 0; t < TEXELS; t++) begin
            if (idx == IDX_W'(t)) begin
                sel = sel_e'(blk[ANCH_W + 2*t +: 2]);
            end
        end
    end

endmodule

// File: rtl/xyb_blend.sv
module xyb_blend
    import xyb_pkg::*;
#(
    parameter int CH_W  = 8,
    parameter int SUM_W = CH_W + 3
) (
    input  logic [CH_W-1:0] e0,
    input  logic [CH_W-1:0] e1,
    input  sel_e            sel,
    output logic [CH_W-1:0] q
);

    logic [SUM_W-1:0] wsum;
    logic [SUM_W-1:0] quo;

    // Weighted sum plus one, then floor divide by three: nearest rounding
    always_comb begin
        unique case (sel)
            SEL_NEAR0: wsum = (SUM_W'(e0) << 1) + SUM_W'(e1) + SUM_W'(1);
            SEL_NEAR1: wsum = SUM_W'(e0) + (SUM_W'(e1) << 1) + SUM_W'(1);
            default:   wsum = '0;
        endcase
        quo = wsum / SUM_W'(3);
        unique case (sel)
            SEL_END0: q = e0;
            SEL_END1: q = e1;
            default:  q = quo[CH_W-1:0];
        endcase
    end

    // Result must stay on the segment between the endpoints (R3, R4)
    logic [CH_W-1:0] lo, hi;
    assign lo = (e0 < e1) ? e0 : e1;
    assign hi = (e0 < e1) ? e1 : e0;
    always_comb begin
        if (!$isunknown({e0, e1, sel})) begin
            p_bounds_r3: assert (q >= lo && q <= hi)
                else $error("blend result off segment");
        end
    end

endmodule

// File: rtl/xyb_stage.sv
module xyb_stage
    import xyb_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);

    stage_e state_q, state_d;
    logic   take_in, give_out;

    assign in_ready = (state_q == ST_EMPTY) || out_ready;
    assign take_in  = in_valid && in_ready;
    assign give_out = (state_q == ST_FULL) && out_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (take_in) state_d = ST_FULL;
            ST_FULL:  if (give_out && !take_in) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       out_data <= '0;
        else if (take_in) out_data <= in_data;
    end

    assign out_valid = (state_q == ST_FULL);

    p_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid)
        else $error("accepted request missing next cycle");

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
        else $error("stalled result changed");

    p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid)
        else $error("taken result presented again");

    p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready)
        else $error("request taken while output blocked");

endmodule

// File: rtl/xyb_decode.sv
module xyb_decode
    import xyb_pkg::*;
#(
    parameter int CH_W   = 8,
    parameter int TEXELS = 16,
    parameter int IDX_W  = $clog2(TEXELS),
    parameter int BLK_W  = 4 * CH_W + 2 * TEXELS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BLK_W-1:0]  in_block,
    input  logic [IDX_W-1:0]  in_texel,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CH_W-1:0]   out_x,
    output logic [CH_W-1:0]   out_y
);

    localparam int NCH = 2;

    logic [NCH-1:0][CH_W-1:0] end0, end1, mix;
    sel_e                     sel;
    logic [NCH*CH_W-1:0]      pack_q;

    xyb_fields #(.CH_W(CH_W), .TEXELS(TEXELS), .NCH(NCH)) u_fields (
        .blk  (in_block),
        .idx  (in_texel),
        .end0 (end0),
        .end1 (end1),
        .sel  (sel)
    );

    // One code feeds every channel blender
    for (genvar c = 0; c < NCH; c++) begin : g_blend
        xyb_blend #(.CH_W(CH_W)) u_blend (
            .e0  (end0[c]),
            .e1  (end1[c]),
            .sel (sel),
            .q   (mix[c])
        );
    end

    xyb_stage #(.W(NCH*CH_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (mix),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (pack_q)
    );

    assign out_y = pack_q[CH_W-1:0];
    assign out_x = pack_q[2*CH_W-1:CH_W];

endmodule

// File: tb/sim_xyb_decode.sv
module sim_xyb_decode;

    typedef struct {
        logic [7:0] x;
        logic [7:0] y;
        string      tag;
    } exp_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        in_valid = 0;
    logic        in_ready;
    logic [63:0] in_block = '0;
    logic [3:0]  in_texel = '0;
    logic        out_valid;
    logic        out_ready = 1;
    logic [7:0]  out_x, out_y;

    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc = 0;
    bit   bp = 0;
    bit   done = 0;
    exp_t sb[$];

    always #5 clk = ~clk;

    xyb_decode u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_block(in_block), .in_texel(in_texel), .out_valid(out_valid),
        .out_ready(out_ready), .out_x(out_x), .out_y(out_y)
    );

    function automatic logic [7:0] mixv(input int a, input int b, input int c);
        // nearest of (w0*a + w1*b)/3 via doubled numerator and offset of half a step
        case (c)
            0: return 8'(a);
            1: return 8'(b);
            2: return 8'((2*(2*a + b) + 3) / 6);
            default: return 8'((2*(a + 2*b) + 3) / 6);
        endcase
    endfunction

    function automatic exp_t model(input logic [63:0] b, input logic [3:0] t);
        exp_t e;
        int c;
        c = int'(b[32 + 2*t +: 2]);            // R5 code position
        e.x = mixv(int'(b[15:8]), int'(b[31:24]), c);  // R6: same code, both channels
        e.y = mixv(int'(b[7:0]),  int'(b[23:16]), c);
        case (c)
            0: e.tag = "R1/R5/R6";
            1: e.tag = "R2/R5/R6";
            2: e.tag = "R3/R5/R6";
            default: e.tag = "R4/R5/R6";
        endcase
        return e;
    endfunction

    task automatic check(input string req, input bit ok, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic send(input logic [63:0] b, input logic [3:0] t);
        @(negedge clk);
        in_valid = 1;
        in_block = b;
        in_texel = t;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        sb.push_back(model(b, t));
        @(posedge clk);
        #1 in_valid = 0;
    endtask

    // Monitor: pace the consumer, pop and compare on every transfer
    bit         held = 0;
    logic [15:0] held_v;
    always begin
        @(negedge clk);
        cyc++;
        out_ready = bp ? ((cyc % 3) != 1) : 1'b1;
        #2;
        if (held) begin
            check("R9 hold", out_valid && {out_x, out_y} == held_v,
                  int'({out_valid, out_x, out_y}), int'({1'b1, held_v}));
        end
        if (out_valid) begin
            check("R10 ready", in_ready == out_ready, int'(in_ready), int'(out_ready));
        end
        held = out_valid && !out_ready;
        held_v = {out_x, out_y};
        if (out_valid && out_ready) begin
            if (sb.size() == 0) begin
                check("R9 extra output", 1'b0, int'({out_x, out_y}), 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, {out_x, out_y} == {e.x, e.y},
                      int'({out_x, out_y}), int'({e.x, e.y}));
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] blk;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        #3;
        // R8: reset state
        check("R8 out_valid", out_valid == 0, int'(out_valid), 0);
        check("R8 in_ready", in_ready == 1, int'(in_ready), 1);

        // R7: one-cycle latency, then drain
        blk = {32'h0000_0000, 16'hFA14, 16'h0AC8};
        send(blk, 4'd0);
        #4;
        check("R7 latency", out_valid == 1, int'(out_valid), 1);
        #10;
        check("R9 drained", out_valid == 0, int'(out_valid), 0);

        // Every texel position with every code value, distinct x/y endpoints
        for (int k = 0; k < 4; k++) begin
            logic [31:0] codes;
            for (int t = 0; t < 16; t++) codes[2*t +: 2] = 2'((t + k) % 4);
            blk = {codes, 16'hFA14, 16'h0AC8};
            for (int t = 0; t < 16; t++) send(blk, 4'(t));
        end

        // Extremes: full-scale endpoints both directions, equal endpoints
        blk = {32'hE4E4_E4E4, 16'hFF00, 16'h00FF};
        for (int t = 0; t < 4; t++) send(blk, 4'(t));
        blk = {32'hE4E4_E4E4, 16'h0000, 16'hFFFF};
        for (int t = 0; t < 4; t++) send(blk, 4'(t));
        blk = {32'hE4E4_E4E4, 16'h7F7F, 16'h7F7F};
        for (int t = 0; t < 4; t++) send(blk, 4'(t));
        // Rounding: endpoints one apart
        blk = {32'hE4E4_E4E4, 16'h0102, 16'h0201};
        for (int t = 0; t < 4; t++) send(blk, 4'(t));

        // Random traffic under backpressure
        bp = 1;
        for (int n = 0; n < 400; n++) begin
            send({$urandom, $urandom}, 4'($urandom));
        end
        bp = 0;
        for (int w = 0; w < 50 && sb.size() != 0; w++) @(posedge clk);
        repeat (4) @(posedge clk);
        @(negedge clk);
        #3;
        check("R9 nothing lost", sb.size() == 0, sb.size(), 0);
        check("R9 idle", out_valid == 0, int'(out_valid), 0);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule